// File: doc/BRIEF.md
# Multi-Style TDM Frame Timing Generator

This block produces the timing skeleton for a serial TDM backplane that carries sixteen parallel data streams. From a reference clock running at four ticks per bit cell, it generates the double-rate clock, the bit clock, a frame sync, and a running position made of a time-slot index, a bit index within the slot and a quarter-cell phase. The frame holds 32, 64 or 128 eight-bit slots, which matches stream rates of 2.048, 4.096 and 8.192 Mbps in a 125 us frame. Quarter-cell resolution is what lets the sync edges sit a quarter bit on each side of the frame boundary, and it is also what allows input sampling at the half, three-quarter or end point of a cell.

Two sync styles are available. In the first, an active-low pulse lasts exactly one double-rate period and is centred on the frame boundary. In the second, an active-high pulse covers the whole last bit cell before the boundary. The style and the rate are picked up only when the frame wraps, so the frame in progress is never cut short. Outgoing stream bits change only at bit-clock rising edges. Incoming bits are captured at the selected point, and each capture is reported with a one-tick strobe together with the slot and bit it belongs to. Downstream logic uses the exported slot index, bit index and slot-start strobe to keep in step with the frame.

Top module: `tdm_frame_timer`

## Requirements
- R1: While `rst` is high at a `clk` edge, the position becomes slot 0, bit 0, phase 0. The outputs then read `clk_x1`=1, `clk_x2`=1, `fsync`=0, `slot_start`=0, `rx_valid`=0 and `tx_out`=0. The style, rate and sample selections present during reset take effect at once.
- R2: The phase advances by one on every `clk` tick, cycling 0,1,2,3. `clk_x1` is high in phases 0 and 1 and low in phases 2 and 3. `clk_x2` is high in phases 0 and 2 and low in phases 1 and 3, so it toggles on every tick.
- R3: `bit_idx` advances after phase 3 and wraps from 7 to 0. `slot_idx` advances after bit 7 and wraps to 0 after the last slot. `rate_sel` 0 gives 32 slots, 1 gives 64, and 2 or 3 gives 128.
- R4: With style 0 (`sync_style`=0), `fsync` is low only in two ticks: phase 3 of bit 7 of the last slot, and phase 0 of bit 0 of slot 0. It is high at all other times.
- R5: With style 1, `fsync` is high for all four phases of bit 7 of the last slot and low everywhere else.
- R6: A change of `sync_style` or `rate_sel` takes effect only at the tick where the position wraps from the last phase of the frame to slot 0. Until then the previous style and slot count stay in force.
- R7: `slot_start` is high for exactly the one tick in which a counted advance reaches bit 0, phase 0 of a slot. It is never high in the reset state.
- R8: `tx_out` changes only on a tick that enters phase 0 (a `clk_x1` rising edge). It loads the `tx_in` value present at that edge and holds it for the whole cell.
- R9: `samp_sel` is taken at each cell start and applies to that cell. Value 0 captures `rx_in` at the edge entering phase 2, value 1 at the edge entering phase 3, and values 2 or 3 at the edge leaving phase 3. `rx_valid` is then high for one tick, with `rx_data` holding the captured bits and `rx_slot`/`rx_bit` giving the cell they came from.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, four ticks per bit cell |
| rst | input | 1 | Synchronous active-high reset |
| sync_style | input | 1 | Frame sync style: 0 centred active-low, 1 leading active-high |
| rate_sel | input | 2 | Slots per frame: 0=32, 1=64, 2/3=128 |
| samp_sel | input | 2 | Input capture point: 0 half, 1 three-quarter, 2/3 end of cell |
| tx_in | input | STREAMS | Next bit for each outgoing stream |
| rx_in | input | STREAMS | Incoming stream bits |
| clk_x2 | output | 1 | Double-rate bus clock |
| clk_x1 | output | 1 | Bit clock |
| fsync | output | 1 | Frame sync in the active style |
| slot_idx | output | 7 | Current time slot |
| bit_idx | output | 3 | Current bit within the slot |
| slot_start | output | 1 | One-tick strobe at the first tick of each slot |
| tx_out | output | STREAMS | Outgoing stream bits |
| rx_data | output | STREAMS | Captured incoming bits |
| rx_valid | output | 1 | One-tick capture strobe |
| rx_slot | output | 7 | Slot of the captured cell |
| rx_bit | output | 3 | Bit of the captured cell |

## Verification
The bench changes style and rate in the middle of a frame. A design that applied either at once would shorten the frame or move the sync pulse into the wrong slot. It also runs every rate across several frames and checks the wrap points. A design that counted 128 slots when 32 were selected, or treated code 3 wrongly, would put the boundary in the wrong place. It covers all three capture points, including end-of-cell capture, where a design that tagged the sample with the following cell, or captured a tick late, would report the wrong data, slot or bit. It also checks the sync width in both styles, since a pulse one tick longer or misaligned with the bit clock would break the rule that the sync is centred on the boundary, or leads it by exactly one cell.

// File: rtl/tdm_timing_pkg.sv
package tdm_timing_pkg;

    localparam int unsigned BITS_PER_SLOT = 8;
    localparam int unsigned MIN_SLOTS     = 32;
    localparam int unsigned MAX_SLOTS     = 128;
    localparam int unsigned SLOT_W        = $clog2(MAX_SLOTS);
    localparam int unsigned BIT_W         = $clog2(BITS_PER_SLOT);
    localparam int unsigned PH_W          = 2;

    localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(3);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BITS_PER_SLOT - 1);

    typedef enum logic {
        SYNC_LOW_STRADDLE = 1'b0,
        SYNC_HIGH_LEAD    = 1'b1
    } sync_style_e;

    typedef enum logic [1:0] {
        SAMP_HALF    = 2'd0,
        SAMP_3Q      = 2'd1,
        SAMP_END     = 2'd2,
        SAMP_END_ALT = 2'd3
    } samp_pt_e;

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic [BIT_W-1:0]  bitn;
        logic [PH_W-1:0]   ph;
    } bus_pos_t;

    // Index of the final slot for a rate code; codes 2 and 3 both mean the widest frame.
    function automatic logic [SLOT_W-1:0] last_slot(input logic [1:0] rate);
        int unsigned n;
        n = (rate >= 2'd2) ? MAX_SLOTS : (MIN_SLOTS << rate);
        return SLOT_W'(n - 1);
    endfunction

    // Phase that the position enters on the edge where a capture happens.
    function automatic logic [PH_W-1:0] capture_phase(input samp_pt_e s);
        case (s)
            SAMP_HALF: return PH_W'(2);
            SAMP_3Q:   return PH_W'(3);
            default:   return PH_W'(0);
        endcase
    endfunction

    // Frame sync level for a given position and style.
    function automatic logic sync_level(input bus_pos_t p, input sync_style_e st,
                                        input logic [SLOT_W-1:0] last);
        logic in_last_bit;
        logic first_q;
        logic final_q;
        in_last_bit = (p.slot == last) && (p.bitn == BIT_LAST);
        final_q     = in_last_bit && (p.ph == PH_LAST);
        first_q     = (p.slot == '0) && (p.bitn == '0) && (p.ph == '0);
        if (st == SYNC_LOW_STRADDLE)
            return !(final_q || first_q);
        return in_last_bit;
    endfunction

endpackage

// File: rtl/tdm_frame_counter.sv
module tdm_frame_counter
    import tdm_timing_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  sync_style_e       style_in,
    input  logic [1:0]        rate_in,
    output bus_pos_t          nxt_pos,
    output sync_style_e       nxt_style,
    output logic [SLOT_W-1:0] nxt_last,
    output logic              nxt_counted,
    output logic [SLOT_W-1:0] cur_slot,
    output logic [BIT_W-1:0]  cur_bit,
    output sync_style_e       cur_style
);

    bus_pos_t    pos_q;
    sync_style_e style_q;
    logic [1:0]  rate_q;
    logic [1:0]  nxt_rate;

    // Next position; reset is folded in so every consumer registers from one source.
    always_comb begin
        nxt_pos     = pos_q;
        nxt_style   = style_q;
        nxt_rate    = rate_q;
        nxt_counted = 1'b0;
        if (rst) begin
            nxt_pos   = '0;
            nxt_style = style_in;
            nxt_rate  = rate_in;
        end else begin
            nxt_counted = 1'b1;
            if (pos_q.ph != PH_LAST) begin
                nxt_pos.ph = pos_q.ph + 1'b1;
            end else begin
                nxt_pos.ph = '0;
                if (pos_q.bitn != BIT_LAST) begin
                    nxt_pos.bitn = pos_q.bitn + 1'b1;
                end else begin
                    nxt_pos.bitn = '0;
                    if (pos_q.slot != last_slot(rate_q)) begin
                        nxt_pos.slot = pos_q.slot + 1'b1;
                    end else begin
                        nxt_pos.slot = '0;
                        nxt_style    = style_in;
                        nxt_rate     = rate_in;
                    end
                end
            end
        end
        nxt_last = last_slot(nxt_rate);
    end

    always_ff @(posedge clk) begin
        pos_q   <= nxt_pos;
        style_q <= nxt_style;
        rate_q  <= nxt_rate;
    end

    assign cur_slot  = pos_q.slot;
    assign cur_bit   = pos_q.bitn;
    assign cur_style = style_q;

endmodule

// File: rtl/tdm_sync_gen.sv
module tdm_sync_gen
    import tdm_timing_pkg::*;
(
    input  logic              clk,
    input  bus_pos_t          nxt_pos,
    input  sync_style_e       nxt_style,
    input  logic [SLOT_W-1:0] nxt_last,
    input  logic              nxt_counted,
    output logic              clk_x2,
    output logic              clk_x1,
    output logic              fsync,
    output logic              slot_start
);

    // All timing outputs come straight from flops so the bus clocks are glitch-free.
    always_ff @(posedge clk) begin
        clk_x1     <= ~nxt_pos.ph[1];
        clk_x2     <= ~nxt_pos.ph[0];
        fsync      <= sync_level(nxt_pos, nxt_style, nxt_last);
        slot_start <= nxt_counted && (nxt_pos.bitn == '0) && (nxt_pos.ph == '0);
    end

endmodule

// File: rtl/tdm_data_port.sv
module tdm_data_port
    import tdm_timing_pkg::*;
#(
    parameter int unsigned STREAMS = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  bus_pos_t           nxt_pos,
    input  logic               nxt_counted,
    input  logic [SLOT_W-1:0]  cur_slot,
    input  logic [BIT_W-1:0]   cur_bit,
    input  samp_pt_e           samp_in,
    input  logic [STREAMS-1:0] tx_in,
    input  logic [STREAMS-1:0] rx_in,
    output logic [STREAMS-1:0] tx_out,
    output logic [STREAMS-1:0] rx_data,
    output logic               rx_valid,
    output logic [SLOT_W-1:0]  rx_slot,
    output logic [BIT_W-1:0]   rx_bit
);

    samp_pt_e samp_q;
    logic     cell_start;
    logic     capture;

    assign cell_start = (nxt_pos.ph == '0);
    assign capture    = nxt_counted && (nxt_pos.ph == capture_phase(samp_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_out   <= '0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
            rx_slot  <= '0;
            rx_bit   <= '0;
            samp_q   <= samp_in;
        end else begin
            if (cell_start) begin
                tx_out <= tx_in;
                samp_q <= samp_in;
            end
            rx_valid <= capture;
            if (capture) begin
                rx_data <= rx_in;
                rx_slot <= cur_slot;
                rx_bit  <= cur_bit;
            end
        end
    end

endmodule

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer
    import tdm_timing_pkg::*;
#(
    parameter int unsigned STREAMS = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sync_style,
    input  logic [1:0]         rate_sel,
    input  logic [1:0]         samp_sel,
    input  logic [STREAMS-1:0] tx_in,
    input  logic [STREAMS-1:0] rx_in,
    output logic               clk_x2,
    output logic               clk_x1,
    output logic               fsync,
    output logic [SLOT_W-1:0]  slot_idx,
    output logic [BIT_W-1:0]   bit_idx,
    output logic               slot_start,
    output logic [STREAMS-1:0] tx_out,
    output logic [STREAMS-1:0] rx_data,
    output logic               rx_valid,
    output logic [SLOT_W-1:0]  rx_slot,
    output logic [BIT_W-1:0]   rx_bit
);

    bus_pos_t          nxt_pos;
    sync_style_e       nxt_style;
    sync_style_e       act_style;
    logic [SLOT_W-1:0] nxt_last;
    logic              nxt_counted;

    tdm_frame_counter u_cnt (
        .clk        (clk),
        .rst        (rst),
        .style_in   (sync_style_e'(sync_style)),
        .rate_in    (rate_sel),
        .nxt_pos    (nxt_pos),
        .nxt_style  (nxt_style),
        .nxt_last   (nxt_last),
        .nxt_counted(nxt_counted),
        .cur_slot   (slot_idx),
        .cur_bit    (bit_idx),
        .cur_style  (act_style)
    );

    tdm_sync_gen u_sync (
        .clk        (clk),
        .nxt_pos    (nxt_pos),
        .nxt_style  (nxt_style),
        .nxt_last   (nxt_last),
        .nxt_counted(nxt_counted),
        .clk_x2     (clk_x2),
        .clk_x1     (clk_x1),
        .fsync      (fsync),
        .slot_start (slot_start)
    );

    tdm_data_port #(.STREAMS(STREAMS)) u_data (
        .clk        (clk),
        .rst        (rst),
        .nxt_pos    (nxt_pos),
        .nxt_counted(nxt_counted),
        .cur_slot   (slot_idx),
        .cur_bit    (bit_idx),
        .samp_in    (samp_pt_e'(samp_sel)),
        .tx_in      (tx_in),
        .rx_in      (rx_in),
        .tx_out     (tx_out),
        .rx_data    (rx_data),
        .rx_valid   (rx_valid),
        .rx_slot    (rx_slot),
        .rx_bit     (rx_bit)
    );

endmodule

// File: rtl/tdm_frame_timer_chk.sv
module tdm_frame_timer_chk
    import tdm_timing_pkg::*;
#(
    parameter int unsigned STREAMS = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               clk_x2,
    input logic               clk_x1,
    input logic               fsync,
    input logic               slot_start,
    input logic [SLOT_W-1:0]  slot_idx,
    input logic [BIT_W-1:0]   bit_idx,
    input logic [STREAMS-1:0] tx_out,
    input logic               rx_valid,
    input logic               act_style
);

    // R2
    x2_toggles_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (clk_x2 != $past(clk_x2)));

    // R2
    x1_rise_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(clk_x1) |-> clk_x2);

    // R3
    slot_step_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_start && slot_idx != '0) |-> (slot_idx == SLOT_W'($past(slot_idx) + 1'b1)));

    // R4
    low_pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        (act_style == 1'b0 && $past(act_style) == 1'b0 && !fsync && !$past(fsync)) |=> fsync);

    // R5
    high_pulse_start_chk: assert property (@(posedge clk) disable iff (rst)
        (act_style == 1'b1 && $rose(fsync)) |-> (clk_x1 && clk_x2));

    // R7
    slot_start_pos_chk: assert property (@(posedge clk) disable iff (rst)
        slot_start |-> (bit_idx == '0 && clk_x1 && clk_x2));

    // R7
    slot_start_single_chk: assert property (@(posedge clk) disable iff (rst)
        slot_start |=> !slot_start);

    // R8
    tx_on_x1_rise_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(tx_out) |-> $rose(clk_x1));

    // R9
    rx_strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

endmodule

bind tdm_frame_timer tdm_frame_timer_chk #(.STREAMS(STREAMS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .clk_x2     (clk_x2),
    .clk_x1     (clk_x1),
    .fsync      (fsync),
    .slot_start (slot_start),
    .slot_idx   (slot_idx),
    .bit_idx    (bit_idx),
    .tx_out     (tx_out),
    .rx_valid   (rx_valid),
    .act_style  (act_style)
);

// File: tb/tb_tdm_frame_timer.sv
module tb_tdm_frame_timer;

    localparam int CLK_PERIOD = 10;
    localparam int STREAMS    = 16;

    logic               clk = 1'b0;
    logic               rst;
    logic               sync_style;
    logic [1:0]         rate_sel;
    logic [1:0]         samp_sel;
    logic [STREAMS-1:0] tx_in;
    logic [STREAMS-1:0] rx_in;
    logic               clk_x2, clk_x1, fsync, slot_start, rx_valid;
    logic [6:0]         slot_idx, rx_slot;
    logic [2:0]         bit_idx, rx_bit;
    logic [STREAMS-1:0] tx_out, rx_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    tdm_frame_timer #(.STREAMS(STREAMS)) dut (
        .clk(clk), .rst(rst), .sync_style(sync_style), .rate_sel(rate_sel),
        .samp_sel(samp_sel), .tx_in(tx_in), .rx_in(rx_in),
        .clk_x2(clk_x2), .clk_x1(clk_x1), .fsync(fsync), .slot_idx(slot_idx),
        .bit_idx(bit_idx), .slot_start(slot_start), .tx_out(tx_out),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_slot(rx_slot), .rx_bit(rx_bit)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Reference model state
    int m_slot, m_bit, m_ph, m_style, m_rate, m_samp;
    int m_tx, m_rxd, m_rxs, m_rxb;
    bit m_ss, m_rv;

    function automatic int last_of(int r);
        return ((r >= 2) ? 128 : (32 << r)) - 1;
    endfunction

    function automatic int exp_fsync();
        bit last_bit;
        last_bit = (m_slot == last_of(m_rate)) && (m_bit == 7);
        if (m_style == 0)
            return ((last_bit && m_ph == 3) || (m_slot == 0 && m_bit == 0 && m_ph == 0)) ? 0 : 1;
        return last_bit ? 1 : 0;
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic step();
        int o_slot, o_bit, o_samp, tgt;
        bit in_reset;
        bit cfg_pending;
        @(posedge clk);
        in_reset = rst;
        if (in_reset) begin
            m_slot = 0; m_bit = 0; m_ph = 0;
            m_style = sync_style; m_rate = rate_sel; m_samp = samp_sel;
            m_tx = 0; m_ss = 0; m_rv = 0;
        end else begin
            o_slot = m_slot; o_bit = m_bit; o_samp = m_samp;
            if (m_ph < 3) m_ph++;
            else begin
                m_ph = 0;
                if (m_bit < 7) m_bit++;
                else begin
                    m_bit = 0;
                    if (m_slot < last_of(m_rate)) m_slot++;
                    else begin
                        m_slot = 0;
                        m_style = sync_style;
                        m_rate = rate_sel;
                    end
                end
            end
            m_ss = (m_ph == 0 && m_bit == 0);
            if (m_ph == 0) begin
                m_tx = tx_in;
                m_samp = samp_sel;
            end
            tgt = (o_samp == 0) ? 2 : (o_samp == 1) ? 3 : 0;
            m_rv = (m_ph == tgt);
            if (m_rv) begin
                m_rxd = rx_in; m_rxs = o_slot; m_rxb = o_bit;
            end
        end
        @(negedge clk);
        cfg_pending = (int'(sync_style) != m_style) || (int'(rate_sel) != m_rate);
        if (in_reset) begin
            chk("R1", "clk_x1", clk_x1, 1);
            chk("R1", "clk_x2", clk_x2, 1);
            chk("R1", "fsync", fsync, 0);
            chk("R1", "slot_idx", slot_idx, 0);
            chk("R1", "bit_idx", bit_idx, 0);
            chk("R1", "slot_start", slot_start, 0);
            chk("R1", "rx_valid", rx_valid, 0);
            chk("R1", "tx_out", tx_out, 0);
        end else begin
            chk("R2", "clk_x1", clk_x1, (m_ph < 2) ? 1 : 0);
            chk("R2", "clk_x2", clk_x2, (m_ph % 2 == 0) ? 1 : 0);
            chk("R3", "slot_idx", slot_idx, m_slot);
            chk("R3", "bit_idx", bit_idx, m_bit);
            if (cfg_pending)        chk("R6", "fsync", fsync, exp_fsync());
            else if (m_style == 0)  chk("R4", "fsync", fsync, exp_fsync());
            else                    chk("R5", "fsync", fsync, exp_fsync());
            chk("R7", "slot_start", slot_start, m_ss);
            chk("R8", "tx_out", tx_out, m_tx);
            chk("R9", "rx_valid", rx_valid, m_rv);
            if (m_rv) begin
                chk("R9", "rx_data", rx_data, m_rxd);
                chk("R9", "rx_slot", rx_slot, m_rxs);
                chk("R9", "rx_bit", rx_bit, m_rxb);
            end
        end
        tx_in = STREAMS'($urandom);
        rx_in = STREAMS'($urandom);
    endtask

    task automatic run(int n, bit rnd_cfg);
        for (int i = 0; i < n; i++) begin
            if (rnd_cfg) begin
                if ($urandom_range(0, 399) == 0) begin
                    sync_style = 1'($urandom_range(0, 1));
                    rate_sel   = 2'($urandom_range(0, 3));
                end
                if ($urandom_range(0, 49) == 0)
                    samp_sel = 2'($urandom_range(0, 3));
            end
            step();
        end
    endtask

    task automatic finish_run();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog all requirements actual running expected done");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; sync_style = 1'b0; rate_sel = 2'd0; samp_sel = 2'd0;
        tx_in = '0; rx_in = '0;
        @(negedge clk);
        run(3, 0);                       // R1 reset values
        rst = 1'b0;
        run(1100, 0);                    // style 0, 32 slots, half-cell capture
        sync_style = 1'b1; rate_sel = 2'd1; samp_sel = 2'd1;
        run(2200, 0);                    // R6: change mid-frame, then style 1 at 64 slots
        sync_style = 1'b0; rate_sel = 2'd2; samp_sel = 2'd2;
        run(4300, 0);                    // 128 slots, end-of-cell capture
        sync_style = 1'b1; rate_sel = 2'd3; samp_sel = 2'd3;
        run(4300, 0);                    // alternate codes for widest frame and end capture
        rst = 1'b1; sync_style = 1'b1; rate_sel = 2'd0; samp_sel = 2'd1;
        run(2, 0);                       // R1 mid-run reset with new config
        rst = 1'b0;
        run(20000, 1);                   // random traffic and config changes
        finish_run();
    end

endmodule